// File: doc/BRIEF.md
# Keyed One-Shot Write Guard for Clock-Control Registers

This block sits on a simple memory-mapped register bus and protects a clock-control register from accidental writes. Software unlocks it by writing a fixed 8-bit key (0x96) into a separate key register. The key arms exactly one write to the protected register. As soon as that write lands, the key register clears itself, so every later protected write needs a fresh key write first. A write to the protected register while the key is wrong is dropped without any other effect.

The same key also qualifies one bit of a second, clock-option register. That bit is the enable for the stabilization wait after wake-up, at bit position 2. The other bits of that register can be written freely. A parameter selects whether a write to the clock-option register uses up the key. By default it does not. Reads are never blocked. The bus has independent write and read addresses, and read data is combinational from the registered state.

Top module: `keyed_write_guard`

## Requirements
- R1: After a synchronous active-low reset, the key register reads 0x00, the protected register reads 0x00 and the clock-option register reads 0x04.
- R2: A write of any value to the key register (offset 0x4019E) stores it, and a read at that offset returns it on the next cycle. A value other than 0x96 leaves the guard disarmed.
- R3: While the key register holds 0x96, a write to the protected register (offset 0x40180) replaces all its bits on the next clock edge.
- R4: A write to the protected register that is accepted clears the key register to 0x00 at the same edge.
- R5: While the key is not 0x96, a write to the protected register leaves both the protected register and the key register unchanged.
- R6: A second protected write that follows a consuming write without a new key write is dropped.
- R7: In the clock-option register (offset 0x40190), bit 2 changes on a write only while the key is 0x96. All other bits take the written data on every write.
- R8: With the default setting, a write to the clock-option register leaves the key register unchanged, so a later protected write is still accepted.
- R9: A read of the protected register returns its contents whatever the key holds. A read of an unmapped offset returns 0x00.
- R10: A read issued during a cycle that consumes the key returns the key value from before that cycle. A protected write in the cycle right after a key write uses the newly written key.
- R11: A write to an unmapped offset changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read offset, independent of the write offset |
| rd_data | output | DATA_W | Combinational read data |
| pwr_ctrl_o | output | DATA_W | Current protected-register contents |
| clk_opt_o | output | DATA_W | Current clock-option register contents |

## Verification
The functions that can share a cycle are the consuming protected write and a key readback on the independent read address. The bench holds the read address on the key register while it issues an armed protected write. It checks that the read returns 0x96 during that cycle and 0x00 right after the edge. A key write followed at once by a protected write, with no idle cycle between them, shows that the newly stored key takes effect at the next edge. A clock-option write made while the key is armed, followed by a protected write, shows that the option write did not use up the key.

// File: rtl/kwg_pkg.sv
// Package: shared types for the keyed write guard.
// Assumes: one decoded target per bus offset; unmapped offsets map to SEL_NONE.
package kwg_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PWR  = 2'd1,
        SEL_KEY  = 2'd2,
        SEL_OPT  = 2'd3
    } kwg_sel_e;
endpackage

// File: rtl/kwg_addr_decode.sv
// Module: kwg_addr_decode
// Maps a bus offset to one of the register targets.
// Assumes: the three offsets are distinct; any other offset selects nothing.
module kwg_addr_decode
    import kwg_pkg::*;
#(
    parameter int                ADDR_W   = 20,
    parameter logic [ADDR_W-1:0] PWR_ADDR = 20'h40180,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 20'h4019E,
    parameter logic [ADDR_W-1:0] OPT_ADDR = 20'h40190
) (
    input  logic [ADDR_W-1:0] addr,
    output kwg_sel_e          sel
);
    // Purpose: exact-match compare of the offset against each target.
    always_comb begin
        if (addr == PWR_ADDR)      sel = SEL_PWR;
        else if (addr == KEY_ADDR) sel = SEL_KEY;
        else if (addr == OPT_ADDR) sel = SEL_OPT;
        else                       sel = SEL_NONE;
    end
endmodule

// File: rtl/kwg_key_reg.sv
// Module: kwg_key_reg
// Holds the unlock key. It loads any written value, clears itself when
// a guarded write consumes it, and flags when it holds the unlock value.
// Assumes: load and consume never coincide on a single write port; if they
// did, consume would win.
module kwg_key_reg #(
    parameter int               KEY_W     = 8,
    parameter logic [KEY_W-1:0] KEY_VALUE = 8'h96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [KEY_W-1:0] load_val,
    input  logic             consume,
    output logic [KEY_W-1:0] key_q,
    output logic             armed
);
    // Purpose: key storage with a clear-on-consume path.
    always_ff @(posedge clk) begin
        if (!rst_n)       key_q <= '0;
        else if (consume) key_q <= '0;
        else if (load_en) key_q <= load_val;
    end

    // Purpose: the guard opens only on an exact key match.
    assign armed = (key_q == KEY_VALUE);
endmodule

// File: rtl/kwg_guarded_reg.sv
// Module: kwg_guarded_reg
// Register with a per-bit guard mask. Guarded bits update only while
// unlocked; unguarded bits update on every write.
// Assumes: wr_en is already qualified by address decode.
module kwg_guarded_reg #(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] RST_VAL    = '0,
    parameter logic [DATA_W-1:0] GUARD_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              unlocked,
    output logic [DATA_W-1:0] q
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (GUARD_MASK[i]) begin : g_guarded
            // Purpose: guarded bit, written only while the key is armed.
            always_ff @(posedge clk) begin
                if (!rst_n)                q[i] <= RST_VAL[i];
                else if (wr_en && unlocked) q[i] <= wr_data[i];
            end
        end else begin : g_free
            // Purpose: free bit, written on every write.
            always_ff @(posedge clk) begin
                if (!rst_n)     q[i] <= RST_VAL[i];
                else if (wr_en) q[i] <= wr_data[i];
            end
        end
    end
endmodule

// File: rtl/keyed_write_guard.sv
// Module: keyed_write_guard (top)
// Guards a clock-control register and one bit of a clock-option register
// behind a one-shot key. Reads are combinational and never gated.
// Assumes: one write per cycle; the read port is independent of the write port.
module keyed_write_guard
    import kwg_pkg::*;
#(
    parameter int                ADDR_W       = 20,
    parameter int                DATA_W       = 8,
    parameter int                KEY_W        = 8,
    parameter logic [KEY_W-1:0]  KEY_VALUE    = 8'h96,
    parameter logic [ADDR_W-1:0] PWR_ADDR     = 20'h40180,
    parameter logic [ADDR_W-1:0] KEY_ADDR     = 20'h4019E,
    parameter logic [ADDR_W-1:0] OPT_ADDR     = 20'h40190,
    parameter int                GUARD_BIT    = 2,
    parameter logic [DATA_W-1:0] PWR_RST      = 8'h00,
    parameter logic [DATA_W-1:0] OPT_RST      = 8'h04,
    parameter bit                OPT_USES_KEY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] pwr_ctrl_o,
    output logic [DATA_W-1:0] clk_opt_o
);
    localparam logic [DATA_W-1:0] PWR_MASK = '1;
    localparam logic [DATA_W-1:0] OPT_MASK = DATA_W'(1) << GUARD_BIT;

    kwg_sel_e         wr_sel;
    kwg_sel_e         rd_sel;
    logic             pwr_we;
    logic             key_we;
    logic             opt_we;
    logic             opt_consume;
    logic             key_consume;
    logic [KEY_W-1:0] key_q;
    logic             key_armed;
    logic [DATA_W-1:0] key_rd;

    kwg_addr_decode #(
        .ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR), .KEY_ADDR(KEY_ADDR), .OPT_ADDR(OPT_ADDR)
    ) u_wr_dec (
        .addr(wr_addr),
        .sel (wr_sel)
    );

    kwg_addr_decode #(
        .ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR), .KEY_ADDR(KEY_ADDR), .OPT_ADDR(OPT_ADDR)
    ) u_rd_dec (
        .addr(rd_addr),
        .sel (rd_sel)
    );

    // Purpose: qualify the write strobe per target.
    assign pwr_we = wr_en && (wr_sel == SEL_PWR);
    assign key_we = wr_en && (wr_sel == SEL_KEY);
    assign opt_we = wr_en && (wr_sel == SEL_OPT);

    if (OPT_USES_KEY) begin : g_opt_consume
        // Purpose: an armed option write also uses up the key.
        assign opt_consume = opt_we && key_armed;
    end else begin : g_opt_keep
        // Purpose: option writes leave the key in place.
        assign opt_consume = 1'b0;
    end

    // Purpose: only an accepted guarded write clears the key.
    assign key_consume = (pwr_we && key_armed) || opt_consume;

    kwg_key_reg #(
        .KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE)
    ) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (key_we),
        .load_val(wr_data[KEY_W-1:0]),
        .consume (key_consume),
        .key_q   (key_q),
        .armed   (key_armed)
    );

    kwg_guarded_reg #(
        .DATA_W(DATA_W), .RST_VAL(PWR_RST), .GUARD_MASK(PWR_MASK)
    ) u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pwr_we),
        .wr_data (wr_data),
        .unlocked(key_armed),
        .q       (pwr_ctrl_o)
    );

    kwg_guarded_reg #(
        .DATA_W(DATA_W), .RST_VAL(OPT_RST), .GUARD_MASK(OPT_MASK)
    ) u_opt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (opt_we),
        .wr_data (wr_data),
        .unlocked(key_armed),
        .q       (clk_opt_o)
    );

    // Purpose: zero-extend the key for the read path.
    always_comb begin
        key_rd              = '0;
        key_rd[KEY_W-1:0]   = key_q;
    end

    // Purpose: ungated read multiplexer.
    always_comb begin
        unique case (rd_sel)
            SEL_PWR: rd_data = pwr_ctrl_o;
            SEL_KEY: rd_data = key_rd;
            SEL_OPT: rd_data = clk_opt_o;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/kwg_checker.sv
// Module: kwg_checker
// Temporal checks on the keyed write guard, attached by bind.
// Assumes: it sees the top's ports and its key register.
module kwg_checker #(
    parameter int                ADDR_W       = 20,
    parameter int                DATA_W       = 8,
    parameter int                KEY_W        = 8,
    parameter logic [KEY_W-1:0]  KEY_VALUE    = 8'h96,
    parameter logic [ADDR_W-1:0] PWR_ADDR     = 20'h40180,
    parameter logic [ADDR_W-1:0] KEY_ADDR     = 20'h4019E,
    parameter logic [ADDR_W-1:0] OPT_ADDR     = 20'h40190,
    parameter int                GUARD_BIT    = 2,
    parameter bit                OPT_USES_KEY = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] pwr_ctrl_o,
    input logic [DATA_W-1:0] clk_opt_o,
    input logic [KEY_W-1:0]  key_q
);
    localparam logic [DATA_W-1:0] FREE_MASK = ~(DATA_W'(1) << GUARD_BIT);

    assert_reset_key_R1: assert property (@(posedge clk)
        !rst_n |=> (key_q == '0));

    assert_key_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == KEY_ADDR) |=> (key_q == $past(wr_data[KEY_W-1:0])));

    assert_pwr_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PWR_ADDR && key_q == KEY_VALUE) |=> (pwr_ctrl_o == $past(wr_data)));

    assert_key_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PWR_ADDR && key_q == KEY_VALUE) |=> (key_q == '0));

    assert_pwr_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PWR_ADDR && key_q != KEY_VALUE) |=> ($stable(pwr_ctrl_o) && $stable(key_q)));

    assert_opt_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OPT_ADDR && key_q != KEY_VALUE) |=> $stable(clk_opt_o[GUARD_BIT]));

    assert_opt_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OPT_ADDR) |=> ((clk_opt_o & FREE_MASK) == ($past(wr_data) & FREE_MASK)));

    if (!OPT_USES_KEY) begin : g_opt_keep_chk
        assert_opt_keeps_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == OPT_ADDR) |=> $stable(key_q));
    end

    assert_read_pwr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == PWR_ADDR) |-> (rd_data == pwr_ctrl_o));

    assert_read_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == KEY_ADDR) |-> (rd_data[KEY_W-1:0] == key_q));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pwr_ctrl_o) && $stable(clk_opt_o) && $stable(key_q)));
endmodule

bind keyed_write_guard kwg_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE),
    .PWR_ADDR(PWR_ADDR), .KEY_ADDR(KEY_ADDR), .OPT_ADDR(OPT_ADDR),
    .GUARD_BIT(GUARD_BIT), .OPT_USES_KEY(OPT_USES_KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .pwr_ctrl_o(pwr_ctrl_o),
    .clk_opt_o (clk_opt_o),
    .key_q     (key_q)
);

// File: tb/keyed_write_guard_tb.sv
// Directed bench for keyed_write_guard: one task per scenario.
module keyed_write_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] A_PWR  = 20'h40180;
    localparam logic [19:0] A_KEY  = 20'h4019E;
    localparam logic [19:0] A_OPT  = 20'h40190;
    localparam logic [19:0] A_NONE = 20'h40184;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [19:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic [7:0]  pwr_ctrl_o;
    logic [7:0]  clk_opt_o;

    int n_checks = 0;
    int n_fail   = 0;

    keyed_write_guard u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwr_ctrl_o(pwr_ctrl_o), .clk_opt_o(clk_opt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [19:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr2(input logic [19:0] a1, input logic [7:0] d1,
                       input logic [19:0] a2, input logic [7:0] d2);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a1; wr_data = d1;
        @(negedge clk);
        wr_addr = a2; wr_data = d2;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(A_KEY, d); check("R1 key after reset", d, 8'h00);
        rd(A_PWR, d); check("R1 pwr after reset", d, 8'h00);
        rd(A_OPT, d); check("R1 opt after reset", d, 8'h04);
        check("R1 pwr_ctrl_o", pwr_ctrl_o, 8'h00);
    endtask

    task automatic t_key_store();
        logic [7:0] d;
        wr(A_KEY, 8'h5A); rd(A_KEY, d); check("R2 key holds 5A", d, 8'h5A);
        wr(A_KEY, 8'h96); rd(A_KEY, d); check("R2 key holds 96", d, 8'h96);
        wr(A_KEY, 8'h00); rd(A_KEY, d); check("R2 key replaced by 00", d, 8'h00);
    endtask

    task automatic t_locked();
        logic [7:0] d;
        wr(A_PWR, 8'hA5);
        check("R5 pwr unchanged, key 00", pwr_ctrl_o, 8'h00);
        wr(A_KEY, 8'h5A);
        wr(A_PWR, 8'hA5);
        check("R5 pwr unchanged, key 5A", pwr_ctrl_o, 8'h00);
        rd(A_KEY, d); check("R5 wrong key kept", d, 8'h5A);
    endtask

    task automatic t_unlock();
        logic [7:0] d;
        wr(A_KEY, 8'h96);
        wr(A_PWR, 8'h3C);
        check("R3 armed write lands", pwr_ctrl_o, 8'h3C);
        rd(A_KEY, d); check("R4 key cleared", d, 8'h00);
        wr(A_PWR, 8'hFF);
        check("R6 second write dropped", pwr_ctrl_o, 8'h3C);
    endtask

    task automatic t_option();
        logic [7:0] d;
        wr(A_OPT, 8'hFB);
        rd(A_OPT, d); check("R7 free bits written, bit2 held", d, 8'hFF);
        wr(A_KEY, 8'h96);
        wr(A_OPT, 8'h00);
        rd(A_OPT, d); check("R7 bit2 cleared when armed", d, 8'h00);
        rd(A_KEY, d); check("R8 option write keeps key", d, 8'h96);
        wr(A_PWR, 8'h81);
        check("R8 key still usable", pwr_ctrl_o, 8'h81);
    endtask

    task automatic t_reads();
        logic [7:0] d;
        rd(A_PWR, d); check("R9 read disarmed", d, 8'h81);
        wr(A_KEY, 8'h96);
        rd(A_PWR, d); check("R9 read armed", d, 8'h81);
        rd(A_NONE, d); check("R9 unmapped read", d, 8'h00);
        wr(A_KEY, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        wr2(A_KEY, 8'h96, A_PWR, 8'h42);
        check("R10 back-to-back key then write", pwr_ctrl_o, 8'h42);
        wr(A_KEY, 8'h96);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_PWR; wr_data = 8'h17;
        rd(A_KEY, d); check("R10 read during consume", d, 8'h96);
        @(posedge clk); #1;
        check("R10 read after consume", rd_data, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 consuming write landed", pwr_ctrl_o, 8'h17);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        wr(A_KEY, 8'h96);
        wr(A_NONE, 8'hFF);
        check("R11 pwr unchanged", pwr_ctrl_o, 8'h17);
        check("R11 opt unchanged", clk_opt_o, 8'h00);
        rd(A_KEY, d); check("R11 key unchanged", d, 8'h96);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_key_store();
        t_locked();
        t_unlock();
        t_option();
        t_reads();
        t_same_cycle();
        t_unmapped();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule